// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit collects the events that an I2C master's bus engine reports and turns them into a single interrupt line. Each event arrives as a one-cycle pulse and is held in a sticky status bit until software clears it. Software can read the pending events in two ways. The first is a status register whose bits are cleared by writing ones. The second is a coded vector register that names one pending event and retires that event as a side effect of the read.

A 5-bit enable register selects which of the five main events may raise the interrupt. The receive-overrun and transmit-underflow error bits are sticky and visible in status, but they never drive the interrupt line. Bit 12 of status shows the bus-busy input as a live level.

Register access uses a 2-bit address. Address 0 is status, 1 is enable, 2 is the vector and 3 reads as zero. Read data is combinational from the current state. Writes and read side effects take place on the rising clock edge.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, status reads 0 apart from bit 12, enable reads 0, the vector reads 0 and irq_o is low.
- R2: A one-cycle event pulse sets its sticky status bit, and the bit reads back set from the cycle after the pulse. The bit positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, transmit underflow 10 and receive overrun 11.
- R3: A write to status (address 0) clears each sticky bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse arrives in the same cycle as a clear of its bit, by a status write or by a vector read, the bit stays set.
- R5: Status bit 12 always equals bus_busy_i, and writes do not change it. Status bits 15:13 and 9:5 read 0.
- R6: The enable register (address 1) stores write-data bits 4:0, using the same positions as the status events, and reads 0 in bits 15:5. Writing 0 to it masks every source, so irq_o is low.
- R7: irq_o is high exactly when status bits 4:0 ANDed with the enable bits are nonzero. The overrun and underflow bits never raise it.
- R8: The vector (address 2) reads 0 when none of status bits 4:0 is set. Otherwise it reads the code of the pending event with the lowest code: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5. The enable register does not affect the vector.
- R9: A read of the vector clears only the status bit whose code it returned, effective from the next cycle. Reads of status or enable change nothing.
- R10: Address 3 reads 0, and writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_al_i | input | 1 | Arbitration-lost pulse |
| evt_nack_i | input | 1 | No-acknowledge pulse |
| evt_ardy_i | input | 1 | Access-ready pulse |
| evt_rrdy_i | input | 1 | Receive-ready pulse |
| evt_xrdy_i | input | 1 | Transmit-ready pulse |
| evt_xudf_i | input | 1 | Transmit-underflow pulse |
| evt_rovr_i | input | 1 | Receive-overrun pulse |
| bus_busy_i | input | 1 | Bus-busy level |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and irq_o are derived combinationally from registered state and bus_busy_i. A value is therefore visible in the same cycle that its address is presented, with no added delay. Event pulses, status clears, enable writes and vector-read clears are captured on one rising edge and show up right after that edge, so their effects appear one cycle after the stimulus. The bench drives every input on the falling edge and samples half a nanosecond later. Each check therefore sees either the state before the next rising edge or the result of exactly one edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_MAIN = 5;
  localparam int NUM_STICKY = 7;
  localparam int DATA_W = 16;
  localparam int VEC_W = 3;
  localparam int ADDR_W = 2;

  localparam int POS_XUDF = 10;
  localparam int POS_ROVR = 11;
  localparam int POS_BUSY = 12;

  localparam int IDX_XUDF = 5;
  localparam int IDX_ROVR = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_EN   = 2'd1,
    A_VEC  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[i] <= 1'b0;
      else         q_o[i] <= (q_o[i] & ~clr_i[i]) | set_i[i];  // set wins
    end
  end
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] code_o,
  output logic [N-1:0] sel_o
);
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        code_o = W'(i + 1);
        sel_o  = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_al_i,
  input  logic              evt_nack_i,
  input  logic              evt_ardy_i,
  input  logic              evt_rrdy_i,
  input  logic              evt_xrdy_i,
  input  logic              evt_xudf_i,
  input  logic              evt_rovr_i,
  input  logic              bus_busy_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_STICKY-1:0] evt_set, evt_clr, sticky_q;
  logic [NUM_MAIN-1:0]   en_q, vec_sel;
  logic [VEC_W-1:0]      vec_code;
  logic [DATA_W-1:0]     stat_view;
  logic                  stat_wr, en_wr, vec_rd;

  assign evt_set = {evt_rovr_i, evt_xudf_i, evt_xrdy_i, evt_rrdy_i,
                    evt_ardy_i, evt_nack_i, evt_al_i};

  assign stat_wr = reg_we_i && (reg_addr_i == A_STAT);
  assign en_wr   = reg_we_i && (reg_addr_i == A_EN);
  assign vec_rd  = reg_re_i && (reg_addr_i == A_VEC);

  for (genvar i = 0; i < NUM_MAIN; i++) begin : g_main_clr
    assign evt_clr[i] = (stat_wr && reg_wdata_i[i]) || (vec_rd && vec_sel[i]);
  end
  assign evt_clr[IDX_XUDF] = stat_wr && reg_wdata_i[POS_XUDF];
  assign evt_clr[IDX_ROVR] = stat_wr && reg_wdata_i[POS_ROVR];

  irq_sticky_bank #(.N(NUM_STICKY)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_set),
    .clr_i (evt_clr),
    .q_o   (sticky_q)
  );

  irq_vec_enc #(.N(NUM_MAIN), .W(VEC_W)) u_enc (
    .pend_i(sticky_q[NUM_MAIN-1:0]),
    .code_o(vec_code),
    .sel_o (vec_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_wr) en_q <= reg_wdata_i[NUM_MAIN-1:0];
  end

  always_comb begin
    stat_view                 = '0;
    stat_view[NUM_MAIN-1:0]   = sticky_q[NUM_MAIN-1:0];
    stat_view[POS_XUDF]       = sticky_q[IDX_XUDF];
    stat_view[POS_ROVR]       = sticky_q[IDX_ROVR];
    stat_view[POS_BUSY]       = bus_busy_i;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_STAT:  reg_rdata_o = stat_view;
      A_EN:    reg_rdata_o = DATA_W'(en_q);
      A_VEC:   reg_rdata_o = DATA_W'(vec_code);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(sticky_q[NUM_MAIN-1:0] & en_q);
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        evt_al_i,
  input logic        evt_nack_i,
  input logic [6:0]  evt_set,
  input logic [6:0]  sticky_q,
  input logic [4:0]  en_q,
  input logic [1:0]  reg_addr_i,
  input logic        reg_we_i,
  input logic        reg_re_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic        bus_busy_i,
  input logic        irq_o
);
  // R2
  al_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_al_i |=> sticky_q[0]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[1] && !evt_nack_i) |=> !sticky_q[1]);

  // R4
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0 && reg_wdata_i[0] && evt_al_i) |=> sticky_q[0]);

  // R5
  busy_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_o[12] == bus_busy_i));

  // R6
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 5'd0) |-> !irq_o);

  // R7
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sticky_q[4:0] != 5'd0));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !(reg_re_i && reg_addr_i == 2'd2) && evt_set == 7'd0) |=> $stable(sticky_q));

  // R9
  vec_one_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == 2'd2 && !reg_we_i && evt_set == 7'd0 && sticky_q[4:0] != 5'd0)
      |=> ($countones(sticky_q[4:0]) == $countones($past(sticky_q[4:0])) - 1));
endmodule

bind i2c_irq_unit i2c_irq_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_al_i   (evt_al_i),
  .evt_nack_i (evt_nack_i),
  .evt_set    (evt_set),
  .sticky_q   (sticky_q),
  .en_q       (en_q),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .bus_busy_i (bus_busy_i),
  .irq_o      (irq_o)
);

// File: tb/i2c_irq_unit_bench.sv
`timescale 1ns/1ps
module i2c_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evts = '0;
  logic        busy = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_irq_unit u_i2c_irq_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_al_i(evts[0]), .evt_nack_i(evts[1]), .evt_ardy_i(evts[2]),
    .evt_rrdy_i(evts[3]), .evt_xrdy_i(evts[4]), .evt_xudf_i(evts[5]),
    .evt_rovr_i(evts[6]), .bus_busy_i(busy),
    .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [15:0] stat_of(input logic [6:0] m, input logic b);
    return {3'b000, b, m[6], m[5], 5'b00000, m[4:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [6:0] e);
    evts = e; cyc(); evts = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; we = 1'b1; wdata = d; cyc(); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; re = 1'b1; #0.5; d = rdata; cyc(); re = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [6:0]  m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd(0, d); chk("R1 stat", d, 16'h0000);
    rd(1, d); chk("R1 en", d, 16'h0000);
    rd(2, d); chk("R1 vec", d, 16'h0000);
    #0.5; chk("R1 irq", {15'd0, irq}, 16'd0);

    // R2: each event alone
    for (int k = 0; k < 7; k++) begin
      pulse(7'(1 << k));
      rd(0, d); chk("R2 set", d, stat_of(7'(1 << k), 1'b0));
      wr(0, 16'hFFFF);
    end

    // R3
    pulse(7'h7F);
    wr(0, 16'h0805);
    rd(0, d); chk("R3 partial", d, stat_of(7'b0111010, 1'b0));
    wr(0, 16'h0000);
    rd(0, d); chk("R3 zero keeps", d, stat_of(7'b0111010, 1'b0));
    wr(0, 16'hFFFF);
    rd(0, d); chk("R3 all", d, 16'h0000);

    // R4: status write clear against event
    evts = 7'b0000100; addr = 2'd0; we = 1'b1; wdata = 16'h0004; cyc();
    evts = '0; we = 1'b0; wdata = '0;
    rd(0, d); chk("R4 w1c race", d, stat_of(7'b0000100, 1'b0));
    // R4: vector read clear against event
    evts = 7'b0000100; addr = 2'd2; re = 1'b1; cyc();
    evts = '0; re = 1'b0;
    rd(0, d); chk("R4 vec race", d, stat_of(7'b0000100, 1'b0));
    wr(0, 16'hFFFF);

    // R5
    busy = 1'b1;
    rd(0, d); chk("R5 busy hi", d, 16'h1000);
    wr(0, 16'hFFFF);
    rd(0, d); chk("R5 write ignored", d, 16'h1000);
    busy = 1'b0;
    rd(0, d); chk("R5 busy lo", d, 16'h0000);

    // R6
    wr(1, 16'hFFFF);
    rd(1, d); chk("R6 en readback", d, 16'h001F);
    pulse(7'h1F);
    wr(1, 16'h0000);
    #0.5; chk("R6 masked", {15'd0, irq}, 16'd0);

    // R7: sweep events x enables
    for (int p = 0; p < 32; p++) begin
      wr(0, 16'hFFFF);
      pulse(7'(p));
      for (int e = 0; e < 32; e++) begin
        wr(1, 16'(e));
        #0.5;
        chk("R7 irq", {15'd0, irq}, {15'd0, |(p[4:0] & e[4:0])});
      end
    end
    wr(0, 16'hFFFF);
    wr(1, 16'h001F);
    pulse(7'b1100000);
    #0.5; chk("R7 err no irq", {15'd0, irq}, 16'd0);
    wr(0, 16'hFFFF);

    // R8 R9: vector sweep, enable has no influence
    wr(1, 16'h0000);
    for (int p = 1; p < 32; p++) begin
      wr(0, 16'hFFFF);
      pulse(7'(p));
      m = 7'(p);
      while (m[4:0] != 5'd0) begin
        int lo;
        lo = 0;
        for (int i = 4; i >= 0; i--) if (m[i]) lo = i;
        rd(2, d); chk("R8 code", d, 16'(lo + 1));
        m[lo] = 1'b0;
        rd(0, d); chk("R9 one cleared", d, stat_of(m, 1'b0));
      end
      rd(2, d); chk("R8 empty", d, 16'h0000);
    end

    // R9: status/enable reads have no side effect
    pulse(7'b0010010);
    rd(0, d); rd(1, d);
    rd(0, d); chk("R9 reads passive", d, stat_of(7'b0010010, 1'b0));

    // R10
    rd(3, d); chk("R10 addr3", d, 16'h0000);
    wr(2, 16'hFFFF); wr(3, 16'hFFFF);
    rd(0, d); chk("R10 no write", d, stat_of(7'b0010010, 1'b0));
    rd(1, d); chk("R10 en kept", d, 16'h0000);

    summary();
    $finish;
  end
endmodule